// File: doc/BRIEF.md
# Disk Sector Transaction Sequencer

This block runs one whole-sector transfer on a moving-head cartridge disk. A host-side controller hands it a command (read the sector, write the sector, rewrite only the data record, or rewrite the label and data records), a target sector number and a one-cycle start strobe. The sequencer then waits until the drive reports the requested sector passing under the head. After that it walks the three records of the sector in their fixed order: header, label, data.

For each record the sequencer issues one request to a shared field engine. The request carries the direction, the word count, the preamble length and the memory base address. The sequencer then waits for the engine to report completion. It owns the read gate and the combined write/erase gate. When a sector changes from reading to writing between two records, it drops the read gate and lets a fixed number of word times of the old postamble pass before it turns the write gate on. That way the new preamble lands roughly where the old one was.

A failed record ends the transaction at once. The sequencer then reports done together with a latched error code and the index of the record that failed.

Top module: `sector_txn_seq`

## Requirements
- R1: After reset, busy, done, err, fe_go, read_gate and write_gate are all low.
- R2: An accepted command does not issue its first field request until a sector_mark pulse arrives whose sector_num equals the commanded sector (0 to SECTORS-1). Marks for other sectors are skipped.
- R3: Each transaction issues its requests in record order 0 (header), 1 (label), 2 (data). The word counts are HDR_WORDS, LBL_WORDS and DAT_WORDS, the base addresses are BASE, BASE+HDR_WORDS and BASE+HDR_WORDS+LBL_WORDS, and fe_go is a single-cycle pulse per request.
- R4: cmd_op encoding: 0 read sector, 1 write sector, 2 update data, 3 update label and data. For op 0 every request has fe_write=0. For op 1 every request has fe_write=1.
- R5: Op 2 requests read, read, write (fe_write 0, 0, 1).
- R6: Op 3 requests read, write, write (fe_write 0, 1, 1).
- R7: At a read-to-write change between records, read_gate falls when the read record completes. Exactly CUT_WAIT word_tick pulses (3 by default) are counted with both gates low, and then write_gate rises with the next request.
- R8: fe_pre is PRE_WR_FIRST (34) for a written header and PRE_RD_FIRST (21) for a read header. A write following a read gets PRE_WR_CUT (4), a write following a write gets PRE_WR_NEXT (3), and a read after the header gets PRE_RD_NEXT (4).
- R9: read_gate is high only while a read record is in progress. write_gate stays high from the first written record until done. The two gates are never high together.
- R10: A completion with fe_err set ends the transaction. done pulses with err=1, err_code equal to fe_err_code (1 sync timeout, 2 checksum) and err_rec equal to the failing record index, and no further request is issued.
- R11: busy rises in the cycle after a command is accepted and stays high until done. A cmd_valid seen while busy has no effect on the running transaction.
- R12: done is a one-cycle pulse that coincides with busy falling. A transaction that completes without error reports err=0, even if the previous one failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start strobe, one cycle |
| cmd_op | input | 2 | Command code (see R4) |
| cmd_sector | input | SECW | Target sector number |
| sector_mark | input | 1 | Pulse as a sector begins under the head |
| sector_num | input | SECW | Number of the sector whose mark is pulsing |
| word_tick | input | 1 | One pulse per disk word time |
| fe_go | output | 1 | Field engine start pulse |
| fe_write | output | 1 | Field engine direction, 1 = write |
| fe_words | output | WORDW | Record length in words |
| fe_addr | output | ADDRW | Memory base address of the record |
| fe_pre | output | PREW | Preamble length in words |
| fe_done | input | 1 | Field engine completion pulse |
| fe_err | input | 1 | Error flag, valid with fe_done |
| fe_err_code | input | 2 | Error cause, valid with fe_done |
| read_gate | output | 1 | Read enable to the drive |
| write_gate | output | 1 | Combined write and erase enable to the drive |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished, one cycle |
| err | output | 1 | Last transaction failed |
| err_code | output | 2 | Cause of the last failure |
| err_rec | output | 2 | Record index that failed |

## Verification
The bench counts word ticks between the fall of read_gate and the rise of write_gate in both update commands. A design whose cutover counter is off by one, or that starts counting while the read record is still running, reports the wrong count. Each request is compared against a table built from the command code, so a swapped mode rule for the two update commands, or a preamble chosen from the wrong predecessor record, is caught at the request where it happens. Errors are injected on a read header and on a written label. A design that keeps sequencing after a failure issues an extra request, and one that does not clear the error flag shows a stale err on the next clean transaction. A conflicting command sent in the middle of a transaction must leave every later request unchanged.

// File: rtl/sector_txn_pkg.sv
package sector_txn_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_UPD_DATA = 2'd2,
    OP_UPD_LD   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ISSUE,
    S_RUN,
    S_CUT
  } st_e;

  // Direction of a record (0 header, 1 label, 2 data) for a command.
  function automatic logic rec_writes(op_e op, logic [1:0] rec);
    case (op)
      OP_READ:     rec_writes = 1'b0;
      OP_WRITE:    rec_writes = 1'b1;
      OP_UPD_DATA: rec_writes = (rec == 2'd2);
      default:     rec_writes = (rec != 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/sector_rec_plan.sv
module sector_rec_plan
  import sector_txn_pkg::*;
#(
  parameter int WORDW        = 9,
  parameter int ADDRW        = 10,
  parameter int PREW         = 6,
  parameter int HDR_WORDS    = 2,
  parameter int LBL_WORDS    = 8,
  parameter int DAT_WORDS    = 256,
  parameter int BASE         = 0,
  parameter int PRE_WR_FIRST = 34,
  parameter int PRE_RD_FIRST = 21,
  parameter int PRE_WR_NEXT  = 3,
  parameter int PRE_WR_CUT   = 4,
  parameter int PRE_RD_NEXT  = 4
) (
  input  op_e              op,
  input  logic [1:0]       rec,
  output logic             wr,
  output logic [WORDW-1:0] words,
  output logic [ADDRW-1:0] addr,
  output logic [PREW-1:0]  pre
);
  localparam int ADDR_LBL = BASE + HDR_WORDS;
  localparam int ADDR_DAT = BASE + HDR_WORDS + LBL_WORDS;

  logic prev_wr;

  always_comb begin
    wr      = rec_writes(op, rec);
    prev_wr = (rec != 2'd0) && rec_writes(op, rec - 2'd1);
    case (rec)
      2'd0: begin
        words = WORDW'(HDR_WORDS);
        addr  = ADDRW'(BASE);
      end
      2'd1: begin
        words = WORDW'(LBL_WORDS);
        addr  = ADDRW'(ADDR_LBL);
      end
      default: begin
        words = WORDW'(DAT_WORDS);
        addr  = ADDRW'(ADDR_DAT);
      end
    endcase
    if (rec == 2'd0)
      pre = wr ? PREW'(PRE_WR_FIRST) : PREW'(PRE_RD_FIRST);
    else if (!wr)
      pre = PREW'(PRE_RD_NEXT);
    else
      pre = prev_wr ? PREW'(PRE_WR_NEXT) : PREW'(PRE_WR_CUT);
  end
endmodule

// File: rtl/sector_cut_timer.sv
module sector_cut_timer #(
  parameter int CUT_WAIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expire
);
  localparam int CW = (CUT_WAIT > 1) ? $clog2(CUT_WAIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CUT_WAIT - 1);

  logic [CW-1:0] cnt;
  logic          active;

  assign expire = active && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (expire) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sector_txn_seq.sv
module sector_txn_seq
  import sector_txn_pkg::*;
#(
  parameter int SECTORS      = 12,
  parameter int HDR_WORDS    = 2,
  parameter int LBL_WORDS    = 8,
  parameter int DAT_WORDS    = 256,
  parameter int BASE         = 0,
  parameter int ADDRW        = 10,
  parameter int PREW         = 6,
  parameter int PRE_WR_FIRST = 34,
  parameter int PRE_RD_FIRST = 21,
  parameter int PRE_WR_NEXT  = 3,
  parameter int PRE_WR_CUT   = 4,
  parameter int PRE_RD_NEXT  = 4,
  parameter int CUT_WAIT     = 3,
  localparam int SECW  = $clog2(SECTORS),
  localparam int WORDW = $clog2(DAT_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SECW-1:0]  cmd_sector,
  input  logic             sector_mark,
  input  logic [SECW-1:0]  sector_num,
  input  logic             word_tick,
  output logic             fe_go,
  output logic             fe_write,
  output logic [WORDW-1:0] fe_words,
  output logic [ADDRW-1:0] fe_addr,
  output logic [PREW-1:0]  fe_pre,
  input  logic             fe_done,
  input  logic             fe_err,
  input  logic [1:0]       fe_err_code,
  output logic             read_gate,
  output logic             write_gate,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic [1:0]       err_rec
);
  st_e              st;
  op_e              op_q;
  logic [SECW-1:0]  tgt_q;
  logic [1:0]       rec_q;
  logic             plan_wr;
  logic [WORDW-1:0] plan_words;
  logic [ADDRW-1:0] plan_addr;
  logic [PREW-1:0]  plan_pre;
  logic             last_rec, rec_ok, cut_load, cut_expire;

  sector_rec_plan #(
    .WORDW(WORDW), .ADDRW(ADDRW), .PREW(PREW),
    .HDR_WORDS(HDR_WORDS), .LBL_WORDS(LBL_WORDS), .DAT_WORDS(DAT_WORDS),
    .BASE(BASE), .PRE_WR_FIRST(PRE_WR_FIRST), .PRE_RD_FIRST(PRE_RD_FIRST),
    .PRE_WR_NEXT(PRE_WR_NEXT), .PRE_WR_CUT(PRE_WR_CUT), .PRE_RD_NEXT(PRE_RD_NEXT)
  ) plan_i (
    .op(op_q), .rec(rec_q), .wr(plan_wr),
    .words(plan_words), .addr(plan_addr), .pre(plan_pre)
  );

  // Cutover needed when a read record completes and the next one writes.
  assign last_rec = (rec_q == 2'd2);
  assign rec_ok   = (st == S_RUN) && fe_done && !fe_err;
  assign cut_load = rec_ok && !last_rec && !plan_wr &&
                    rec_writes(op_q, rec_q + 2'd1);

  sector_cut_timer #(.CUT_WAIT(CUT_WAIT)) cut_i (
    .clk(clk), .rst(rst), .load(cut_load), .tick(word_tick), .expire(cut_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      op_q       <= OP_READ;
      tgt_q      <= '0;
      rec_q      <= '0;
      fe_go      <= 1'b0;
      fe_write   <= 1'b0;
      fe_words   <= '0;
      fe_addr    <= '0;
      fe_pre     <= '0;
      read_gate  <= 1'b0;
      write_gate <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_code   <= '0;
      err_rec    <= '0;
    end else begin
      fe_go <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q     <= op_e'(cmd_op);
          tgt_q    <= cmd_sector;
          rec_q    <= '0;
          busy     <= 1'b1;
          err      <= 1'b0;
          err_code <= '0;
          err_rec  <= '0;
          st       <= S_WAIT;
        end
        S_WAIT: if (sector_mark && sector_num == tgt_q) st <= S_ISSUE;
        S_ISSUE: begin
          fe_go    <= 1'b1;
          fe_write <= plan_wr;
          fe_words <= plan_words;
          fe_addr  <= plan_addr;
          fe_pre   <= plan_pre;
          if (plan_wr) write_gate <= 1'b1;
          else         read_gate  <= 1'b1;
          st <= S_RUN;
        end
        S_RUN: if (fe_done) begin
          read_gate <= 1'b0;
          if (fe_err || last_rec) begin
            write_gate <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b1;
            err        <= fe_err;
            err_code   <= fe_err ? fe_err_code : 2'd0;
            err_rec    <= fe_err ? rec_q : 2'd0;
            st         <= S_IDLE;
          end else begin
            rec_q <= rec_q + 2'd1;
            st    <= cut_load ? S_CUT : S_ISSUE;
          end
        end
        S_CUT: if (cut_expire) st <= S_ISSUE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_txn_seq_chk.sv
module sector_txn_seq_chk (
  input logic clk,
  input logic rst,
  input logic fe_go,
  input logic read_gate,
  input logic write_gate,
  input logic busy,
  input logic done,
  input logic err
);
  a_r9_gates_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(read_gate && write_gate));

  a_r9_write_gate_held: assert property (@(posedge clk) disable iff (rst)
    $fell(write_gate) |-> done);

  a_r11_go_needs_busy: assert property (@(posedge clk) disable iff (rst)
    fe_go |-> busy);

  a_r11_idle_gates_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!read_gate && !write_gate));

  a_r3_go_single: assert property (@(posedge clk) disable iff (rst)
    fe_go |=> !fe_go);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_err_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

bind sector_txn_seq sector_txn_seq_chk chk_i (
  .clk(clk), .rst(rst), .fe_go(fe_go), .read_gate(read_gate),
  .write_gate(write_gate), .busy(busy), .done(done), .err(err)
);

// File: tb/sector_txn_seq_tb.sv
module sector_txn_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_sector = 4'd0;
  logic       sector_mark = 1'b0;
  logic [3:0] sector_num = 4'd0;
  logic       word_tick = 1'b0;
  logic       fe_go, fe_write;
  logic [8:0] fe_words;
  logic [9:0] fe_addr;
  logic [5:0] fe_pre;
  logic       fe_done = 1'b0;
  logic       fe_err = 1'b0;
  logic [1:0] fe_err_code = 2'd0;
  logic       read_gate, write_gate, busy, done, err;
  logic [1:0] err_code, err_rec;

  sector_txn_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .sector_mark(sector_mark), .sector_num(sector_num),
    .word_tick(word_tick), .fe_go(fe_go), .fe_write(fe_write),
    .fe_words(fe_words), .fe_addr(fe_addr), .fe_pre(fe_pre),
    .fe_done(fe_done), .fe_err(fe_err), .fe_err_code(fe_err_code),
    .read_gate(read_gate), .write_gate(write_gate), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .err_rec(err_rec)
  );

  always #5 clk = ~clk;

  int vecs = 0, bad = 0, cyc = 0;
  // Reference state for the running transaction.
  int cur_op = 0, cur_sec = 0, inj_rec = -1, inj_code = 0;
  int req_idx = 0, done_cnt = 0, last_sec = -1;
  int eng_cnt = 0, eng_rec = 0;
  int tick_cnt = 0;
  bit armed = 1'b0;
  bit p_rg = 1'b0, p_wg = 1'b0, p_busy = 1'b0, p_done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit ref_wr(input int op, input int r);
    case (op)
      0: return 1'b0;
      1: return 1'b1;
      2: return r == 2;
      default: return r != 0;
    endcase
  endfunction

  function automatic int ref_pre(input int op, input int r);
    if (r == 0) return ref_wr(op, 0) ? 34 : 21;
    if (!ref_wr(op, r)) return 4;
    return ref_wr(op, r - 1) ? 3 : 4;
  endfunction

  function automatic int ref_words(input int r);
    return (r == 0) ? 2 : (r == 1) ? 8 : 256;
  endfunction

  function automatic int ref_addr(input int r);
    return (r == 0) ? 0 : (r == 1) ? 2 : 10;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
    if (!rst) begin
      // Per-cycle comparisons (R9, R11, R12)
      chk(!(read_gate && write_gate), "R9 gates both high", int'(write_gate), 0);
      if (!busy) chk(!read_gate && !write_gate, "R11 gate while idle",
                     int'(read_gate) + int'(write_gate), 0);
      if (p_done) chk(!done, "R12 done longer than one cycle", int'(done), 0);
      if (p_wg && !write_gate) chk(done, "R9 write_gate dropped early", int'(done), 1);
      if (done) chk(p_busy && !busy, "R12 busy fall at done", int'(busy), 0);
      if (sector_mark) last_sec = int'(sector_num);
      // Cutover window (R7)
      if (p_rg && !read_gate) begin
        tick_cnt = 0;
        armed    = 1'b1;
      end
      if (word_tick && p_busy && !p_rg && !p_wg && armed) tick_cnt++;
      if (!p_wg && write_gate && (cur_op >= 2))
        chk(armed && tick_cnt == 3, "R7 cutover word ticks", tick_cnt, 3);
      // Field engine requests (R2..R6, R8)
      if (fe_go) begin
        chk(req_idx <= 2, "R3 request count", req_idx, 2);
        if (req_idx == 0)
          chk(last_sec == cur_sec, "R2 start sector", last_sec, cur_sec);
        chk(fe_write == ref_wr(cur_op, req_idx),
            (cur_op == 2) ? "R5 direction" : (cur_op == 3) ? "R6 direction" : "R4 direction",
            int'(fe_write), int'(ref_wr(cur_op, req_idx)));
        chk(int'(fe_pre) == ref_pre(cur_op, req_idx), "R8 preamble",
            int'(fe_pre), ref_pre(cur_op, req_idx));
        chk(int'(fe_words) == ref_words(req_idx), "R3 word count",
            int'(fe_words), ref_words(req_idx));
        chk(int'(fe_addr) == ref_addr(req_idx), "R3 base address",
            int'(fe_addr), ref_addr(req_idx));
        chk(ref_wr(cur_op, req_idx) ? (write_gate && !read_gate) : (read_gate && !write_gate),
            "R9 gate for record", int'(read_gate), int'(!ref_wr(cur_op, req_idx)));
        eng_rec = req_idx;
        eng_cnt = 5;
        req_idx++;
      end
      if (done) begin
        done_cnt++;
        armed = 1'b0;
        chk(req_idx == ((inj_rec >= 0) ? inj_rec + 1 : 3), "R10 requests before done",
            req_idx, (inj_rec >= 0) ? inj_rec + 1 : 3);
        chk(err == (inj_rec >= 0), (inj_rec >= 0) ? "R10 err flag" : "R12 err cleared",
            int'(err), int'(inj_rec >= 0));
        if (inj_rec >= 0) begin
          chk(int'(err_code) == inj_code, "R10 err_code", int'(err_code), inj_code);
          chk(int'(err_rec) == inj_rec, "R10 err_rec", int'(err_rec), inj_rec);
        end
      end
    end
    p_rg = read_gate; p_wg = write_gate; p_busy = busy; p_done = done;
    // Stimulus: engine, word ticks, sector marks
    fe_done = 1'b0; fe_err = 1'b0; fe_err_code = 2'd0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        fe_done = 1'b1;
        if (eng_rec == inj_rec) begin
          fe_err      = 1'b1;
          fe_err_code = 2'(inj_code);
        end
      end
    end
    word_tick   = (cyc % 8) == 0;
    sector_mark = (cyc % 40) == 0;
    if (sector_mark) sector_num = (sector_num == 4'd11) ? 4'd0 : sector_num + 4'd1;
  end

  task automatic run_cmd(input int op, input int sec, input int irec, input int icode,
                         input bit poke);
    int start;
    @(negedge clk);
    cur_op = op; cur_sec = sec; inj_rec = irec; inj_code = icode;
    req_idx = 0; start = done_cnt;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sector = 4'(sec);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy, "R11 busy after accept", int'(busy), 1);
    if (poke) begin
      while (req_idx < 1 && cyc < 150000) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd1; cmd_sector = 4'(sec + 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy, "R11 busy during ignored command", int'(busy), 1);
    end
    while (done_cnt == start && cyc < 150000) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !fe_go && !read_gate && !write_gate,
        "R1 reset state", int'(busy) + int'(done) + int'(err) + int'(read_gate), 0);
    run_cmd(0, 3, -1, 0, 1'b0);   // R4 read sector
    run_cmd(1, 0, -1, 0, 1'b0);   // R4 write sector
    run_cmd(2, 7, -1, 0, 1'b1);   // R5 update data, R11 ignored command
    run_cmd(3, 11, -1, 0, 1'b0);  // R6 update label and data, R7 cutover
    run_cmd(3, 5, 1, 2, 1'b0);    // R10 checksum error on written label
    run_cmd(0, 9, 0, 1, 1'b0);    // R10 sync timeout on header
    run_cmd(2, 1, -1, 0, 1'b0);   // R12 err cleared by clean transaction
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule